// File: doc/BRIEF.md
# Per-Core Thermal Test-State Sequencer

This block tracks one core under test through a temperature-driven test flow. On each update strobe it compares a sampled core temperature with four programmable thresholds: a lower interval limit, an upper interval limit, a mid-interval heating target and a stop-cooling point. It then decides whether the core should be heated with dummy high-power patterns, tested, left to cool with no patterns, parked until it is selected again, or retired because its test has finished.

A scheduler outside the block pulses the select input when it grants bus width to the core. It reads back which kind of pattern to apply and whether bus width is held. When the core drops out of heating or testing, the block raises a one-cycle release pulse and forgets the selection. The scheduler must select the core again before the core can resume. The block also checks the threshold set on every cycle. An inconsistent set parks the core in the waiting state.

Temperatures are unsigned fixed-point values with two fractional bits, so one step is 0.25 °C. A 10-bit value covers 0 to 255.75 °C.

Top module: `core_thermal_sequencer`

## Requirements
- R1: While reset is asserted, and on the cycle after it, the state output reads waiting (code 0). The heat, test, bus-hold and release outputs are all 0. The state codes are: waiting 0, heating 1, testing 2, cooling 3, complete 4.
- R2: From waiting, a selected core moves to heating when its temperature is at or below the lower limit. It moves to testing when the temperature is above the lower limit and below the upper limit. In every other case it stays in waiting.
- R3: From heating, the core moves to cooling if the temperature is at or above the upper limit. Otherwise it moves to testing once the temperature exceeds its target. The target is the mid limit when the low-power-frame flag is 1 and the lower limit when that flag is 0.
- R4: In testing, a set test-done flag moves the core to complete. Without it, the core moves to cooling when the temperature is at or above the upper limit. It moves to waiting when the temperature is at or below the lower limit, and it stays in testing otherwise.
- R5: In cooling, the core moves to waiting when the temperature is at or below the lower limit. Otherwise it moves to testing when it is selected and the temperature is at or below the stop-cooling limit. In every other case it stays in cooling.
- R6: The heat output is 1 exactly in heating. The test output is 1 exactly in testing. Bus width is held (bus-hold output 1) in both of these states and in no other.
- R7: When the core leaves heating or testing for any other state, the release output is 1 for exactly the next cycle. The selection is cleared at that point, so a cooled core does not resume until it is selected again.
- R8: The state changes only on a cycle where the update strobe is 1. A select pulse that arrives without a strobe is remembered until a strobe uses it.
- R9: Complete is kept until reset, whatever the inputs.
- R10: The configuration-error output is 1 when the stop-cooling limit is below the lower limit, or at or above the upper limit. While it is 1, every strobe sends a core that is not complete to waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Update strobe; the state advances only on this |
| temp_i | input | TW | Core temperature sample, 0.25 °C per step |
| lim_lo_i | input | TW | Lower interval limit |
| lim_hi_i | input | TW | Upper interval limit |
| lim_mid_i | input | TW | Heating target for low-power frames |
| lim_stop_i | input | TW | Stop-cooling limit |
| sel_i | input | 1 | Selection pulse from the bus scheduler |
| lowpwr_i | input | 1 | The next pattern's frame is low-power |
| done_i | input | 1 | All test patterns have been applied |
| state_o | output | 3 | State code |
| heat_o | output | 1 | Apply heating patterns |
| test_o | output | 1 | Apply test patterns |
| bus_req_o | output | 1 | Bus width held |
| bus_rel_o | output | 1 | One-cycle bus-width release pulse |
| cfg_err_o | output | 1 | Threshold set is inconsistent |

## Verification
The assertions take the limits and the temperature to be stable across the cycle in which a strobe is applied. They expect the test-done flag to be meaningful only while the core is testing. A property on a hot testing core assumes that the threshold set is valid on that strobe. The stimulus keeps the limits constant through the long phases. It changes the stop-cooling limit only at phase boundaries, to enter and leave the error cases. It draws temperatures from a band a little wider than the interval, so that every threshold is crossed from both sides with the stop-cooling point strictly inside.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    typedef enum logic [2:0] {
        ST_WAIT = 3'd0,
        ST_HEAT = 3'd1,
        ST_TEST = 3'd2,
        ST_COOL = 3'd3,
        ST_DONE = 3'd4
    } cstate_e;

    // Result of comparing one temperature sample with the threshold set
    typedef struct packed {
        logic le_lo;    // temperature <= lower limit
        logic lt_hi;    // temperature <  upper limit
        logic gt_mid;   // temperature >  mid limit
        logic le_stop;  // temperature <= stop-cooling limit
    } tflags_t;

    // Registered controller state
    typedef struct packed {
        cstate_e st;
        logic    sel;
        logic    rel;
    } ctl_reg_t;

    function automatic logic holds_bus(input cstate_e s);
        return (s == ST_HEAT) || (s == ST_TEST);
    endfunction

endpackage

// File: rtl/ctl_tcmp.sv
module ctl_tcmp
    import ctl_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic [TW-1:0] temp_i,
    input  logic [TW-1:0] lo_i,
    input  logic [TW-1:0] hi_i,
    input  logic [TW-1:0] mid_i,
    input  logic [TW-1:0] stop_i,
    output tflags_t       flags_o
);
    always_comb begin
        flags_o.le_lo   = (temp_i <= lo_i);
        flags_o.lt_hi   = (temp_i <  hi_i);
        flags_o.gt_mid  = (temp_i >  mid_i);
        flags_o.le_stop = (temp_i <= stop_i);
    end
endmodule

// File: rtl/ctl_cfgchk.sv
module ctl_cfgchk #(
    parameter int TW = 10
) (
    input  logic [TW-1:0] lo_i,
    input  logic [TW-1:0] hi_i,
    input  logic [TW-1:0] stop_i,
    output logic          err_o
);
    // The stop-cooling point must lie in [lower, upper)
    always_comb begin
        err_o = (stop_i < lo_i) || (stop_i >= hi_i);
    end
endmodule

// File: rtl/ctl_fsm.sv
module ctl_fsm
    import ctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    upd_i,
    input  tflags_t flags_i,
    input  logic    sel_i,
    input  logic    lowpwr_i,
    input  logic    done_i,
    input  logic    err_i,
    output cstate_e state_o,
    output logic    rel_o
);
    ctl_reg_t r_q, r_d;
    logic     sel_eff;
    logic     heat_ok;
    cstate_e  nxt;

    always_comb begin
        r_d     = r_q;
        sel_eff = r_q.sel | sel_i;
        heat_ok = lowpwr_i ? flags_i.gt_mid : !flags_i.le_lo;
        nxt     = r_q.st;
        r_d.rel = 1'b0;
        r_d.sel = sel_eff;

        if (upd_i) begin
            unique case (r_q.st)
                ST_WAIT: begin
                    if (!err_i && sel_eff) begin
                        if (flags_i.le_lo)      nxt = ST_HEAT;
                        else if (flags_i.lt_hi) nxt = ST_TEST;
                    end
                end
                ST_HEAT: begin
                    if (err_i)               nxt = ST_WAIT;
                    else if (!flags_i.lt_hi) nxt = ST_COOL;
                    else if (heat_ok)        nxt = ST_TEST;
                end
                ST_TEST: begin
                    if (err_i)               nxt = ST_WAIT;
                    else if (done_i)         nxt = ST_DONE;
                    else if (!flags_i.lt_hi) nxt = ST_COOL;
                    else if (flags_i.le_lo)  nxt = ST_WAIT;
                end
                ST_COOL: begin
                    if (err_i)                            nxt = ST_WAIT;
                    else if (flags_i.le_lo)               nxt = ST_WAIT;
                    else if (flags_i.le_stop && sel_eff)  nxt = ST_TEST;
                end
                ST_DONE: nxt = ST_DONE;
                default: nxt = ST_WAIT;
            endcase

            if (holds_bus(r_q.st) && !holds_bus(nxt)) begin
                r_d.rel = 1'b1;
                r_d.sel = 1'b0;
            end
        end
        r_d.st = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_WAIT, sel: 1'b0, rel: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;
    assign rel_o   = r_q.rel;
endmodule

// File: rtl/core_thermal_sequencer.sv
module core_thermal_sequencer
    import ctl_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_i,
    input  logic [TW-1:0] temp_i,
    input  logic [TW-1:0] lim_lo_i,
    input  logic [TW-1:0] lim_hi_i,
    input  logic [TW-1:0] lim_mid_i,
    input  logic [TW-1:0] lim_stop_i,
    input  logic          sel_i,
    input  logic          lowpwr_i,
    input  logic          done_i,
    output logic [2:0]    state_o,
    output logic          heat_o,
    output logic          test_o,
    output logic          bus_req_o,
    output logic          bus_rel_o,
    output logic          cfg_err_o
);
    tflags_t flags;
    logic    err;
    cstate_e st;
    logic    rel;

    ctl_tcmp #(.TW(TW)) u_tcmp (
        .temp_i  (temp_i),
        .lo_i    (lim_lo_i),
        .hi_i    (lim_hi_i),
        .mid_i   (lim_mid_i),
        .stop_i  (lim_stop_i),
        .flags_o (flags)
    );

    ctl_cfgchk #(.TW(TW)) u_cfg (
        .lo_i   (lim_lo_i),
        .hi_i   (lim_hi_i),
        .stop_i (lim_stop_i),
        .err_o  (err)
    );

    ctl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_i    (upd_i),
        .flags_i  (flags),
        .sel_i    (sel_i),
        .lowpwr_i (lowpwr_i),
        .done_i   (done_i),
        .err_i    (err),
        .state_o  (st),
        .rel_o    (rel)
    );

    assign state_o   = st;
    assign heat_o    = (st == ST_HEAT);
    assign test_o    = (st == ST_TEST);
    assign bus_req_o = holds_bus(st);
    assign bus_rel_o = rel;
    assign cfg_err_o = err;
endmodule

// File: rtl/ctl_checker.sv
module ctl_checker #(
    parameter int TW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          upd_i,
    input logic [TW-1:0] temp_i,
    input logic [TW-1:0] lim_hi_i,
    input logic          done_i,
    input logic [2:0]    state_o,
    input logic          bus_req_o,
    input logic          bus_rel_o,
    input logic          cfg_err_o
);
    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(state_o)); // R8

    AST_COMPLETE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |=> (state_o == 3'd4)); // R9

    AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rel_o |-> (!bus_req_o && $past(bus_req_o))); // R7

    AST_BAD_CFG_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && cfg_err_o && state_o != 3'd4) |=> (state_o == 3'd0)); // R10

    AST_HOT_TEST_COOLS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !cfg_err_o && state_o == 3'd2 && !done_i && temp_i >= lim_hi_i)
        |=> (state_o == 3'd3)); // R4
endmodule

bind core_thermal_sequencer ctl_checker #(.TW(TW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_i     (upd_i),
    .temp_i    (temp_i),
    .lim_hi_i  (lim_hi_i),
    .done_i    (done_i),
    .state_o   (state_o),
    .bus_req_o (bus_req_o),
    .bus_rel_o (bus_rel_o),
    .cfg_err_o (cfg_err_o)
);

// File: tb/sim_core_thermal_sequencer.sv
module sim_core_thermal_sequencer;
    localparam int TW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          upd_i = 1'b0;
    logic [TW-1:0] temp_i = '0;
    logic [TW-1:0] lim_lo_i = 10'd340;
    logic [TW-1:0] lim_hi_i = 10'd400;
    logic [TW-1:0] lim_mid_i = 10'd370;
    logic [TW-1:0] lim_stop_i = 10'd360;
    logic          sel_i = 1'b0;
    logic          lowpwr_i = 1'b0;
    logic          done_i = 1'b0;
    logic [2:0]    state_o;
    logic          heat_o, test_o, bus_req_o, bus_rel_o, cfg_err_o;

    always #4 clk = ~clk;

    core_thermal_sequencer #(.TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .temp_i(temp_i),
        .lim_lo_i(lim_lo_i), .lim_hi_i(lim_hi_i), .lim_mid_i(lim_mid_i),
        .lim_stop_i(lim_stop_i), .sel_i(sel_i), .lowpwr_i(lowpwr_i),
        .done_i(done_i), .state_o(state_o), .heat_o(heat_o), .test_o(test_o),
        .bus_req_o(bus_req_o), .bus_rel_o(bus_rel_o), .cfg_err_o(cfg_err_o)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    fin = 1'b0;
    int    e_st = 0;
    bit    e_sel = 1'b0;
    bit    e_rel = 1'b0;
    string tag = "R1";

    task automatic chk(input bit ok, input string t, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    function automatic bit hold(input int s);
        return (s == 1) || (s == 2);
    endfunction

    task automatic compare(input string t);
        bit e_err;
        e_err = (lim_stop_i < lim_lo_i) || (lim_stop_i >= lim_hi_i);
        chk(state_o == 3'(e_st), t, "state", int'(state_o), e_st);
        chk(heat_o == (e_st == 1), "R6", "heat", int'(heat_o), int'(e_st == 1));
        chk(test_o == (e_st == 2), "R6", "test", int'(test_o), int'(e_st == 2));
        chk(bus_req_o == hold(e_st), "R6", "bus_req", int'(bus_req_o), int'(hold(e_st)));
        chk(bus_rel_o == e_rel, "R7", "bus_rel", int'(bus_rel_o), int'(e_rel));
        chk(cfg_err_o == e_err, "R10", "cfg_err", int'(cfg_err_o), int'(e_err));
    endtask

    // Expected next state from the requirements, for the inputs now applied
    task automatic model_step();
        bit err, se, le_lo, lt_hi, rel;
        int ns;
        err   = (lim_stop_i < lim_lo_i) || (lim_stop_i >= lim_hi_i);
        se    = e_sel | sel_i;
        le_lo = temp_i <= lim_lo_i;
        lt_hi = temp_i < lim_hi_i;
        ns    = e_st;
        tag   = "R8";
        if (upd_i) begin
            case (e_st)
                0: begin tag = "R2";
                    if (!err && se) ns = le_lo ? 1 : (lt_hi ? 2 : 0); end
                1: begin tag = "R3";
                    if (err) ns = 0;
                    else if (!lt_hi) ns = 3;
                    else if (lowpwr_i ? (temp_i > lim_mid_i) : !le_lo) ns = 2; end
                2: begin tag = "R4";
                    if (err) ns = 0;
                    else if (done_i) ns = 4;
                    else if (!lt_hi) ns = 3;
                    else if (le_lo) ns = 0; end
                3: begin tag = "R5";
                    if (err || le_lo) ns = 0;
                    else if (temp_i <= lim_stop_i && se) ns = 2; end
                default: begin tag = "R9"; ns = 4; end
            endcase
            if (err && e_st != 4) tag = "R10";
        end
        rel   = upd_i && hold(e_st) && !hold(ns);
        e_sel = rel ? 1'b0 : se;
        e_rel = rel;
        e_st  = ns;
    endtask

    // Apply inputs at a falling edge, step the model, check at the next falling edge
    task automatic step(input int t, input bit s, input bit lp, input bit d, input bit u);
        temp_i = 10'(t); sel_i = s; lowpwr_i = lp; done_i = d; upd_i = u;
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; upd_i = 1'b0; sel_i = 1'b0; done_i = 1'b0;
        e_st = 0; e_sel = 1'b0; e_rel = 1'b0;
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_bad++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int dwell;
        dwell = 0;
        @(negedge clk);
        do_reset();

        // Near-exhaustive sweep across the interval, with phases of bad stop limits
        for (int i = 0; i < 6000; i++) begin
            if (i == 3000) lim_stop_i = 10'd330;      // below lower: error
            if (i == 3600) lim_stop_i = 10'd400;      // equal upper: error
            if (i == 4200) lim_stop_i = 10'd340;      // equal lower: valid
            if (i == 5000) lim_stop_i = 10'd399;      // just below upper: valid
            if (e_st == 4) dwell++;
            if (dwell > 6) begin
                dwell = 0;
                do_reset();
            end else begin
                step(320 + int'($urandom_range(0, 100)), ($urandom_range(0, 3) == 0),
                     $urandom_range(0, 1) == 1, ($urandom_range(0, 60) == 0),
                     ($urandom_range(0, 3) != 0));
            end
        end

        // Directed corner cases
        lim_stop_i = 10'd360;
        do_reset();
        step(340, 1, 0, 0, 0);   // R8: select without strobe, state holds
        chk(state_o == 3'd0, "R8", "no strobe state", int'(state_o), 0);
        step(340, 0, 0, 0, 1);   // R2: remembered selection, at lower limit -> heat
        chk(state_o == 3'd1, "R2", "heat at TL", int'(state_o), 1);
        step(360, 0, 1, 0, 1);   // R3: low-power target is mid, 360 not above 370
        chk(state_o == 3'd1, "R3", "still heating", int'(state_o), 1);
        step(371, 0, 1, 0, 1);   // R3: above mid -> test
        chk(state_o == 3'd2, "R3", "heat to test", int'(state_o), 2);
        step(400, 0, 0, 0, 1);   // R4: at upper -> cool, release
        chk(state_o == 3'd3 && bus_rel_o, "R7", "cool with release", int'(bus_rel_o), 1);
        step(355, 0, 0, 0, 1);   // R7: below stop but selection cleared -> stays
        chk(state_o == 3'd3 && !bus_rel_o, "R7", "no resume unselected", int'(state_o), 3);
        step(355, 1, 0, 0, 1);   // R5: reselected below stop -> test
        chk(state_o == 3'd2, "R5", "cool to test", int'(state_o), 2);
        step(370, 0, 0, 1, 1);   // R4: done -> complete
        chk(state_o == 3'd4, "R4", "complete", int'(state_o), 4);
        step(330, 1, 0, 0, 1);   // R9: absorbing
        chk(state_o == 3'd4 && !bus_req_o, "R9", "complete kept", int'(state_o), 4);
        lim_stop_i = 10'd300;
        step(370, 1, 0, 0, 1);   // R9 and R10: complete survives a bad configuration
        chk(state_o == 3'd4, "R9", "complete under error", int'(state_o), 4);
        lim_stop_i = 10'd360;
        do_reset();
        step(370, 1, 0, 0, 1);   // R2: inside interval -> test directly
        chk(state_o == 3'd2, "R2", "direct test", int'(state_o), 2);
        lim_stop_i = 10'd410;
        step(370, 0, 0, 0, 1);   // R10: error parks in waiting
        chk(state_o == 3'd0 && cfg_err_o, "R10", "parked", int'(state_o), 0);

        fin = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule